// File: doc/BRIEF.md
# ISA Bus Cycle Sequencer

This block is the host-side master for single transfers on an ISA-style expansion bus. A request gives an address, write data, direction, memory or I/O space and a wish for a 16-bit transfer. The block then runs the whole bus cycle: address phase, address-latch pulse, command strobe, wait states and command recovery. It returns read data together with a one-cycle done pulse. Electrical turn-around of the data lines and bus ownership are handled elsewhere.

The block runs from a clock at twice the bus clock, so one clock is a half bus clock. All phase lengths below are counted in these half-clock ticks. The target decides how long each cycle is. Its 16-bit select lines choose between byte timing and word timing. The zero-wait request shortens a 16-bit memory command. The ready line stretches any command, up to a timeout. A word request to a byte-wide target is split into two byte cycles, and the block packs the two bytes into one result.

Top module: `isa_cycle_seq`

## Requirements
- R1: After reset, req_ready is 1, rsp_done is 0, BALE is 0, and SBHE#, all four command strobes and both low-megabyte strobes are high.
- R2: Each cycle drives LA and SA for one tick with BALE low. BALE is then high for exactly one tick. The command follows at once, and the addresses hold their value until the command has ended.
- R3: When the target's 16-bit select is asserted, a memory command lasts 4 ticks. If the zero-wait input is low in the first command tick, it lasts 2 ticks instead.
- R4: When the target's 16-bit select is asserted, an I/O command lasts 3 ticks. With no 16-bit select, a command of either space lasts 9 ticks. The zero-wait input has no effect on either of these.
- R5: The 16-bit select is sampled in the BALE tick. It is taken from the memory select for memory cycles and from the I/O select for I/O cycles. The other select line is ignored.
- R6: If the ready input is low at the end of the minimum command length, the command stays asserted. Once ready is sampled high, the command lasts two more ticks and then ends.
- R7: If ready is still low 250 ticks (125 bus clocks) into the wait, the command ends and rsp_err is 1 with that request's done pulse.
- R8: After each command there is a recovery of 2 ticks after a 16-bit-select cycle and 3 ticks after a byte cycle, with BALE low. rsp_done is a one-tick pulse in the tick after the last recovery.
- R9: SMEMR# and SMEMW# repeat MEMR# and MEMW# one tick later, but only when address bits 23..20 are all zero. Otherwise they stay high.
- R10: For a word request, address bit 0 is forced to 0 and SBHE# is low. If the target does not assert its 16-bit select, the block runs a second byte cycle at the odd address with SBHE# high. The low byte goes first. For a byte request, SBHE# equals the inverse of address bit 0.
- R11: In a byte cycle, the write byte appears on both lanes of SD. It is req_wdata[7:0] for the first or only cycle and req_wdata[15:8] for the second cycle. A read byte is taken from SD[15:8] when the 16-bit select was seen and the address is odd, and from SD[7:0] otherwise. Split reads return {second byte, first byte*. Byte requests return the byte with 8 zero bits above it.
- R12: Only the strobe that matches the space and direction is ever asserted (MEMR#, MEMW#, IOR# or IOW#). A word cycle with the 16-bit select asserted drives and returns all 16 bits of SD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, twice the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start a transfer (taken while req_ready is 1) |
| req_ready | output | 1 | Sequencer idle |
| req_addr | input | 24 | Transfer address |
| req_wdata | input | 16 | Write data |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_wide | input | 1 | Request a 16-bit transfer |
| rsp_done | output | 1 | One-tick completion pulse |
| rsp_err | output | 1 | Ready timeout, valid with rsp_done |
| rsp_rdata | output | 16 | Read result |
| bus_la | output | 7 | Upper latched address bits 23..17 |
| bus_sa | output | 20 | System address bits 19..0 |
| bus_bale | output | 1 | Address latch enable |
| bus_sbhe_n | output | 1 | High byte enable, active low |
| bus_memr_n | output | 1 | Memory read strobe |
| bus_memw_n | output | 1 | Memory write strobe |
| bus_smemr_n | output | 1 | Low-megabyte memory read strobe |
| bus_smemw_n | output | 1 | Low-megabyte memory write strobe |
| bus_ior_n | output | 1 | I/O read strobe |
| bus_iow_n | output | 1 | I/O write strobe |
| bus_sd_out | output | 16 | Data driven to the bus |
| bus_sd_oe | output | 1 | Data output enable (writes) |
| bus_sd_in | input | 16 | Data read from the bus |
| bus_memcs16_n | input | 1 | Target memory is 16 bits wide |
| bus_iocs16_n | input | 1 | Target I/O port is 16 bits wide |
| bus_nowait_n | input | 1 | Target asks for zero wait states |
| bus_rdy | input | 1 | Target ready, low stretches the command |

## Verification
The embedded properties rely on the target behaving like a bus target. The select lines must be stable from the address tick through BALE. Ready may only drop while a command is asserted, and req_valid is only raised while req_ready is 1. The bench's target model keeps to these rules. It sets each select line per byte cycle before BALE and holds zero-wait steady for the whole transfer. It drives ready from a count of command ticks, releasing it after a chosen delay that ranges from none, through short stretches, to a delay past the timeout. Random traffic covers both spaces, both directions, both widths and addresses on both sides of the first megabyte. Directed cases cover zero-wait on I/O, odd-lane reads and the timeout.

// File: rtl/isa_seq_pkg.sv
package isa_seq_pkg;

   typedef enum logic [2:0] {
      S_IDLE,
      S_ADDR,
      S_BALE,
      S_CMD,
      S_WAIT,
      S_HOLD,
      S_RECOV
   } seq_state_t;

   typedef struct packed {
      logic write;
      logic io;
      logic wide;
   } xfer_kind_t;

endpackage

// File: rtl/isa_len_sel.sv
module isa_len_sel #(
   parameter int unsigned T_M16   = 4,
   parameter int unsigned T_M16Z  = 2,
   parameter int unsigned T_IO16  = 3,
   parameter int unsigned T_N8    = 9,
   parameter int unsigned T_REC16 = 2,
   parameter int unsigned T_REC8  = 3,
   parameter int unsigned LEN_W   = 5
) (
   input  logic             is16,
   input  logic             io,
   input  logic             zws,
   output logic [LEN_W-1:0] cmd_len,
   output logic [LEN_W-1:0] rec_len
);

   generate
      if (T_M16Z == 0 || T_M16Z >= T_M16) begin : g_bad_zws
         $error("zero-wait length must be nonzero and below the normal 16-bit length");
      end
      if (T_IO16 == 0 || T_N8 <= T_IO16 || T_N8 <= T_M16) begin : g_bad_byte
         $error("byte command must be longer than the 16-bit commands");
      end
      if (T_REC16 == 0 || T_REC8 == 0) begin : g_bad_rec
         $error("recovery lengths must be nonzero");
      end
      if (T_N8 >= (1 << LEN_W) || T_REC8 >= (1 << LEN_W)) begin : g_bad_w
         $error("phase counter too narrow");
      end
   endgenerate

   always_comb begin
      if (!is16)
         cmd_len = LEN_W'(T_N8);
      else if (io)
         cmd_len = LEN_W'(T_IO16);
      else if (zws)
         cmd_len = LEN_W'(T_M16Z);
      else
         cmd_len = LEN_W'(T_M16);
      rec_len = is16 ? LEN_W'(T_REC16) : LEN_W'(T_REC8);
   end

endmodule

// File: rtl/isa_rdy_timer.sv
module isa_rdy_timer #(
   parameter int unsigned LIMIT = 250,
   parameter int unsigned CW    = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic rdy,
   output logic expired
);

   generate
      if (LIMIT < 2 || (LIMIT - 1) >= (1 << CW)) begin : g_bad_limit
         $error("timeout limit out of range for counter width");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (!run)
         cnt_q <= '0;
      else if (cnt_q != CW'(LIMIT - 1))
         cnt_q <= cnt_q + 1'b1;
   end

   assign expired = run && !rdy && (cnt_q == CW'(LIMIT - 1));

   // R7: expiry needs at least one earlier waiting tick
   p_expire_after_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
      expired |-> $past(run));

endmodule

// File: rtl/isa_lane_map.sv
module isa_lane_map #(
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              cap,
   input  logic              full_word,
   input  logic              second,
   input  logic              hi_lane,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] sd_in,
   output logic [DATA_W-1:0] sd_out,
   output logic [DATA_W-1:0] rdata
);

   localparam int unsigned BW = DATA_W / 2;

   generate
      if (DATA_W < 2 || (DATA_W % 2) != 0) begin : g_bad_dw
         $error("data width must be even");
      end
   endgenerate

   logic [BW-1:0] wbyte;
   logic [BW-1:0] rbyte;

   always_comb begin
      wbyte  = second ? wdata[DATA_W-1:BW] : wdata[BW-1:0];
      sd_out = full_word ? wdata : {wbyte, wbyte};
      rbyte  = hi_lane ? sd_in[DATA_W-1:BW] : sd_in[BW-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rdata <= '0;
      else if (start)
         rdata <= '0;
      else if (cap) begin
         if (full_word)
            rdata <= sd_in;
         else if (second)
            rdata[DATA_W-1:BW] <= rbyte;
         else
            rdata[BW-1:0] <= rbyte;
      end
   end

   // R11: a byte capture never touches the other half of the result
   p_byte_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (cap && !full_word && !second && !start) |=> $stable(rdata[DATA_W-1:BW]));

endmodule

// File: rtl/isa_cycle_seq.sv
module isa_cycle_seq
   import isa_seq_pkg::*;
#(
   parameter int unsigned ADDR_W       = 24,
   parameter int unsigned DATA_W       = 16,
   parameter int unsigned SA_W         = 20,
   parameter int unsigned LA_LO        = 17,
   parameter int unsigned CLK_PER_BCLK = 2,
   parameter int unsigned T_M16        = 4,
   parameter int unsigned T_M16Z       = 2,
   parameter int unsigned T_IO16       = 3,
   parameter int unsigned T_N8         = 9,
   parameter int unsigned T_REC16      = 2,
   parameter int unsigned T_REC8       = 3,
   parameter int unsigned TIMEOUT_BCLK = 125,
   parameter int unsigned SMEM_DLY     = 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_valid,
   output logic                     req_ready,
   input  logic [ADDR_W-1:0]        req_addr,
   input  logic [DATA_W-1:0]        req_wdata,
   input  logic                     req_write,
   input  logic                     req_io,
   input  logic                     req_wide,
   output logic                     rsp_done,
   output logic                     rsp_err,
   output logic [DATA_W-1:0]        rsp_rdata,
   output logic [ADDR_W-LA_LO-1:0]  bus_la,
   output logic [SA_W-1:0]          bus_sa,
   output logic                     bus_bale,
   output logic                     bus_sbhe_n,
   output logic                     bus_memr_n,
   output logic                     bus_memw_n,
   output logic                     bus_smemr_n,
   output logic                     bus_smemw_n,
   output logic                     bus_ior_n,
   output logic                     bus_iow_n,
   output logic [DATA_W-1:0]        bus_sd_out,
   output logic                     bus_sd_oe,
   input  logic [DATA_W-1:0]        bus_sd_in,
   input  logic                     bus_memcs16_n,
   input  logic                     bus_iocs16_n,
   input  logic                     bus_nowait_n,
   input  logic                     bus_rdy
);

   localparam int unsigned TO_TICKS = TIMEOUT_BCLK * CLK_PER_BCLK;
   localparam int unsigned TMR_W    = $clog2(TO_TICKS);
   localparam int unsigned LEN_W    = $clog2(T_N8 + T_REC8 + CLK_PER_BCLK + 1);

   generate
      if (ADDR_W <= SA_W || LA_LO >= SA_W) begin : g_bad_addr
         $error("latched address must overlap the top of the system address");
      end
      if (CLK_PER_BCLK < 1) begin : g_bad_ratio
         $error("clock ratio must be at least one");
      end
   endgenerate

   seq_state_t          st_q;
   xfer_kind_t          kind_q;
   logic [ADDR_W-1:0]   addr_q;
   logic [DATA_W-1:0]   wdata_q;
   logic [LEN_W-1:0]    cnt_q;
   logic                is16_q, zws_q, second_q, split_q, err_q, done_q;

   logic                accept, in_cmd, cs16_now, zws_now, cap, full_word, low_meg;
   logic                tmr_expired;
   logic [LEN_W-1:0]    cmd_len, rec_len;

   assign accept    = req_valid && (st_q == S_IDLE);
   assign in_cmd    = (st_q == S_CMD) || (st_q == S_WAIT) || (st_q == S_HOLD);
   assign cs16_now  = kind_q.io ? !bus_iocs16_n : !bus_memcs16_n;
   assign zws_now   = zws_q || ((st_q == S_CMD) && (cnt_q == '0) && !bus_nowait_n);
   assign full_word = kind_q.wide && is16_q && !split_q;
   assign low_meg   = (addr_q[ADDR_W-1:SA_W] == '0);

   isa_len_sel #(
      .T_M16(T_M16), .T_M16Z(T_M16Z), .T_IO16(T_IO16), .T_N8(T_N8),
      .T_REC16(T_REC16), .T_REC8(T_REC8), .LEN_W(LEN_W)
   ) len_i (
      .is16(is16_q), .io(kind_q.io), .zws(zws_now),
      .cmd_len(cmd_len), .rec_len(rec_len)
   );

   isa_rdy_timer #(.LIMIT(TO_TICKS), .CW(TMR_W)) tmr_i (
      .clk(clk), .rst_n(rst_n), .run(st_q == S_WAIT), .rdy(bus_rdy),
      .expired(tmr_expired)
   );

   always_comb begin
      cap = 1'b0;
      unique case (st_q)
         S_CMD:   cap = (cnt_q == cmd_len - 1'b1) && bus_rdy;
         S_WAIT:  cap = !bus_rdy && tmr_expired;
         S_HOLD:  cap = (cnt_q == LEN_W'(CLK_PER_BCLK - 1));
         default: cap = 1'b0;
      endcase
   end

   isa_lane_map #(.DATA_W(DATA_W)) lane_i (
      .clk(clk), .rst_n(rst_n), .start(accept), .cap(cap),
      .full_word(full_word), .second(second_q), .hi_lane(is16_q && addr_q[0]),
      .wdata(wdata_q), .sd_in(bus_sd_in), .sd_out(bus_sd_out), .rdata(rsp_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= S_IDLE;
         kind_q   <= '0;
         addr_q   <= '0;
         wdata_q  <= '0;
         cnt_q    <= '0;
         is16_q   <= 1'b0;
         zws_q    <= 1'b0;
         second_q <= 1'b0;
         split_q  <= 1'b0;
         err_q    <= 1'b0;
         done_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (st_q)
            S_IDLE: if (req_valid) begin
               addr_q   <= req_wide ? {req_addr[ADDR_W-1:1], 1'b0} : req_addr;
               wdata_q  <= req_wdata;
               kind_q   <= '{write: req_write, io: req_io, wide: req_wide};
               second_q <= 1'b0;
               split_q  <= 1'b0;
               err_q    <= 1'b0;
               st_q     <= S_ADDR;
            end
            S_ADDR: st_q <= S_BALE;
            S_BALE: begin
               is16_q <= cs16_now;
               if (kind_q.wide && !second_q && !cs16_now)
                  split_q <= 1'b1;
               zws_q <= 1'b0;
               cnt_q <= '0;
               st_q  <= S_CMD;
            end
            S_CMD: begin
               cnt_q <= cnt_q + 1'b1;
               if ((cnt_q == '0) && !bus_nowait_n)
                  zws_q <= 1'b1;
               if (cnt_q == cmd_len - 1'b1) begin
                  cnt_q <= '0;
                  st_q  <= bus_rdy ? S_RECOV : S_WAIT;
               end
            end
            S_WAIT: begin
               if (bus_rdy) begin
                  cnt_q <= '0;
                  st_q  <= S_HOLD;
               end else if (tmr_expired) begin
                  err_q <= 1'b1;
                  cnt_q <= '0;
                  st_q  <= S_RECOV;
               end
            end
            S_HOLD: begin
               cnt_q <= cnt_q + 1'b1;
               if (cnt_q == LEN_W'(CLK_PER_BCLK - 1)) begin
                  cnt_q <= '0;
                  st_q  <= S_RECOV;
               end
            end
            S_RECOV: begin
               cnt_q <= cnt_q + 1'b1;
               if (cnt_q == rec_len - 1'b1) begin
                  cnt_q <= '0;
                  if (split_q && !second_q) begin
                     second_q  <= 1'b1;
                     addr_q[0] <= 1'b1;
                     st_q      <= S_ADDR;
                  end else begin
                     done_q <= 1'b1;
                     st_q   <= S_IDLE;
                  end
               end
            end
            default: st_q <= S_IDLE;
         endcase
      end
   end

   assign req_ready  = (st_q == S_IDLE);
   assign rsp_done   = done_q;
   assign rsp_err    = done_q && err_q;
   assign bus_la     = addr_q[ADDR_W-1:LA_LO];
   assign bus_sa     = addr_q[SA_W-1:0];
   assign bus_bale   = (st_q == S_BALE);
   assign bus_sbhe_n = (st_q == S_IDLE) ? 1'b1 : (kind_q.wide ? second_q : ~addr_q[0]);
   assign bus_memr_n = !(in_cmd && !kind_q.io && !kind_q.write);
   assign bus_memw_n = !(in_cmd && !kind_q.io &&  kind_q.write);
   assign bus_ior_n  = !(in_cmd &&  kind_q.io && !kind_q.write);
   assign bus_iow_n  = !(in_cmd &&  kind_q.io &&  kind_q.write);
   assign bus_sd_oe  = kind_q.write && (st_q != S_IDLE);

   logic smemr_raw_n, smemw_raw_n;
   assign smemr_raw_n = bus_memr_n || !low_meg;
   assign smemw_raw_n = bus_memw_n || !low_meg;

   generate
      if (SMEM_DLY != 0) begin : g_smem_reg
         logic smemr_q, smemw_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               smemr_q <= 1'b1;
               smemw_q <= 1'b1;
            end else begin
               smemr_q <= smemr_raw_n;
               smemw_q <= smemw_raw_n;
            end
         end
         assign bus_smemr_n = smemr_q;
         assign bus_smemw_n = smemw_q;

         // R9: the low-megabyte read strobe trails the main read strobe
         p_smemr_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !bus_smemr_n |-> $past(!bus_memr_n));
         p_smemw_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !bus_smemw_n |-> $past(!bus_memw_n));
      end else begin : g_smem_comb
         assign bus_smemr_n = smemr_raw_n;
         assign bus_smemw_n = smemw_raw_n;
      end
   endgenerate

   // R2: address latch pulse lasts one tick, addresses set up a tick before it
   p_bale_one_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_bale |=> !bus_bale);
   p_la_setup_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_bale) |-> ($stable(bus_la) && $stable(bus_sa)));
   p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_cmd && $past(in_cmd)) |-> ($stable(bus_la) && $stable(bus_sa)));
   // R12: never more than one command strobe
   p_one_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({!bus_memr_n, !bus_memw_n, !bus_ior_n, !bus_iow_n}));
   // R6: command held while the target is not ready
   p_hold_not_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q == S_WAIT) && !bus_rdy && !tmr_expired) |=> in_cmd);
   // R7: expiry ends the command with the error flag set
   p_timeout_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q == S_WAIT) && tmr_expired) |=> ((st_q == S_RECOV) && err_q));
   // R8: done is a single-tick pulse with no address latch pulse
   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done);
   p_recov_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == S_RECOV) |-> (!bus_bale && bus_memr_n && bus_memw_n && bus_ior_n && bus_iow_n));

endmodule

// File: tb/isa_cycle_seq_tb_top.sv
module isa_cycle_seq_tb_top;

   localparam int TO = 250;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [23:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic        req_write = 1'b0, req_io = 1'b0, req_wide = 1'b0;
   logic        rsp_done, rsp_err;
   logic [15:0] rsp_rdata;
   logic [6:0]  bus_la;
   logic [19:0] bus_sa;
   logic        bus_bale, bus_sbhe_n, bus_memr_n, bus_memw_n, bus_smemr_n, bus_smemw_n;
   logic        bus_ior_n, bus_iow_n, bus_sd_oe;
   logic [15:0] bus_sd_out;
   logic [15:0] bus_sd_in = '0;
   logic        bus_memcs16_n = 1'b1, bus_iocs16_n = 1'b1, bus_nowait_n = 1'b1, bus_rdy = 1'b1;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   isa_cycle_seq dut_i (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
      .req_wdata(req_wdata), .req_write(req_write), .req_io(req_io), .req_wide(req_wide),
      .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
      .bus_la(bus_la), .bus_sa(bus_sa), .bus_bale(bus_bale), .bus_sbhe_n(bus_sbhe_n),
      .bus_memr_n(bus_memr_n), .bus_memw_n(bus_memw_n),
      .bus_smemr_n(bus_smemr_n), .bus_smemw_n(bus_smemw_n),
      .bus_ior_n(bus_ior_n), .bus_iow_n(bus_iow_n),
      .bus_sd_out(bus_sd_out), .bus_sd_oe(bus_sd_oe), .bus_sd_in(bus_sd_in),
      .bus_memcs16_n(bus_memcs16_n), .bus_iocs16_n(bus_iocs16_n),
      .bus_nowait_n(bus_nowait_n), .bus_rdy(bus_rdy)
   );

   task automatic chk_eq(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic int min_len(bit cs, bit io, bit zws);
      if (!cs) return 9;
      if (io) return 3;
      return zws ? 2 : 4;
   endfunction

   function automatic int exp_len(bit cs, bit io, bit zws, int w);
      int l = min_len(cs, io, zws);
      if (w < l) return l;
      if (w < l + TO) return w + 3;
      return l + TO;
   endfunction

   function automatic bit exp_to(bit cs, bit io, bit zws, int w);
      return w >= min_len(cs, io, zws) + TO;
   endfunction

   function automatic int exp_rec(bit cs);
      return cs ? 2 : 3;
   endfunction

   task automatic run_txn(input logic [23:0] a, input logic [15:0] wd, input bit wr,
                          input bit io, input bit wide, input bit csa, input bit csb,
                          input bit zws, input int w);
      logic [15:0] rd[2];
      logic [23:0] ah[2];
      logic [6:0]  la_s[2];
      logic [19:0] sa_s[2];
      logic        sbhe_s[2];
      logic [15:0] sd_s[2];
      logic        oe_s[2];
      logic        csh[2];
      logic [7:0]  byt[2];
      logic [15:0] exp_rd;
      int len_s[2], bale_w[2], bale_gap;
      int h = 0, c = 0, gap = 0, wrong = 0, smem_lo = 0, smem_bad = 0;
      int done_gap = -1, halves, iter = 0, exp_smem = 0;
      logic got_err = 1'b0;
      logic [15:0] got_rd = '0;
      bit cmd, split, ok_err;
      logic [23:0] base;
      rd[0] = 16'($urandom);
      rd[1] = 16'($urandom);
      csh[0] = csa;
      csh[1] = csb;
      len_s[0] = 0; len_s[1] = 0; bale_w[0] = 0; bale_w[1] = 0; bale_gap = -1;
      split  = wide && !csa;
      halves = split ? 2 : 1;
      base   = wide ? {a[23:1], 1'b0} : a;
      ah[0]  = base;
      ah[1]  = base | 24'h1;

      @(negedge clk);
      req_addr = a; req_wdata = wd; req_write = wr; req_io = io; req_wide = wide;
      req_valid = 1'b1;
      bus_nowait_n = !zws;
      bus_rdy = 1'b1;
      bus_sd_in = rd[0];
      bus_memcs16_n = io ? csa : !csa;
      bus_iocs16_n  = io ? !csa : csa;

      forever begin
         @(negedge clk);
         req_valid = 1'b0;
         iter++;
         cmd = io ? (wr ? !bus_iow_n : !bus_ior_n) : (wr ? !bus_memw_n : !bus_memr_n);
         wrong += (!bus_memr_n + !bus_memw_n + !bus_ior_n + !bus_iow_n) - int'(cmd);
         if (!io && !wr) begin
            if (!bus_smemr_n) smem_lo++;
            if (!bus_smemw_n) smem_bad++;
         end else if (!io && wr) begin
            if (!bus_smemw_n) smem_lo++;
            if (!bus_smemr_n) smem_bad++;
         end else if (!bus_smemr_n || !bus_smemw_n) smem_bad++;
         if (cmd) begin
            c++;
            if (c == 1 && h < 2) begin sd_s[h] = bus_sd_out; oe_s[h] = bus_sd_oe; end
         end else begin
            if (c > 0) begin
               if (h < 2) len_s[h] = c;
               h++;
               c = 0;
               gap = 0;
            end
            gap++;
         end
         if (bus_bale && h < 2) begin
            bale_w[h]++;
            la_s[h] = bus_la; sa_s[h] = bus_sa; sbhe_s[h] = bus_sbhe_n;
            if (h == 1) bale_gap = gap;
         end
         if (rsp_done) begin
            done_gap = gap; got_rd = rsp_rdata; got_err = rsp_err;
            break;
         end
         if (iter > 3000) break;
         bus_rdy = cmd ? (c > w) : 1'b1;
         bus_sd_in = (h == 0) ? rd[0] : rd[1];
         begin
            logic cur;
            cur = (h == 0) ? csa : csb;
            bus_memcs16_n = io ? cur : !cur;
            bus_iocs16_n  = io ? !cur : cur;
         end
      end
      bus_rdy = 1'b1;

      chk_eq("R8", "transfer completes", 32'(iter <= 3000), 32'd1);
      chk_eq("R10", "byte cycle count", 32'(h), 32'(halves));
      for (int k = 0; k < halves; k++) begin
         chk_eq("R3 R4 R5 R6 R7", "command length", 32'(len_s[k]),
                32'(exp_len(csh[k], io, zws, w)));
         chk_eq("R2", "BALE width", 32'(bale_w[k]), 32'd1);
         chk_eq("R2", "latched address", 32'(la_s[k]), 32'(ah[k][23:17]));
         chk_eq("R2", "system address", 32'(sa_s[k]), 32'(ah[k][19:0]));
         chk_eq("R10", "SBHE#", 32'(sbhe_s[k]),
                32'(wide ? (k == 1) : !a[0]));
         chk_eq("R11 R12", "data output enable", 32'(oe_s[k]), 32'(wr));
         if (wr)
            chk_eq("R11 R12", "write lanes", 32'(sd_s[k]),
                   32'((wide && csa) ? wd : (k == 1 ? {wd[15:8], wd[15:8]} : {wd[7:0], wd[7:0]})));
         byt[k] = (csh[k] && ah[k][0]) ? rd[k][15:8] : rd[k][7:0];
         exp_smem += len_s[k];
      end
      if (split) chk_eq("R8", "recovery before second BALE", 32'(bale_gap), 32'(exp_rec(csa) + 2));
      chk_eq("R8", "recovery before done", 32'(done_gap), 32'(exp_rec(csh[halves-1]) + 1));
      chk_eq("R12", "wrong strobe ticks", 32'(wrong), 32'd0);
      chk_eq("R9", "low-megabyte strobe ticks", 32'(smem_lo),
             32'((!io && a[23:20] == 4'h0) ? exp_smem : 0));
      chk_eq("R9", "other low-megabyte strobe", 32'(smem_bad), 32'd0);
      ok_err = exp_to(csa, io, zws, w) || (split && exp_to(csb, io, zws, w));
      chk_eq("R7", "error flag", 32'(got_err), 32'(ok_err));
      if (!wr) begin
         if (wide && csa) exp_rd = rd[0];
         else if (wide) exp_rd = {byt[1], byt[0]};
         else exp_rd = {8'h00, byt[0]};
         chk_eq("R11 R12", "read data", 32'(got_rd), 32'(exp_rd));
      end
      @(negedge clk);
      chk_eq("R8", "done is one tick", 32'(rsp_done), 32'd0);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(20 * 150000);
      n_chk++;
      n_fail++;
      $display("FAIL R8 watchdog: actual running expected finished");
      finish_run();
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk_eq("R1", "ready", 32'(req_ready), 32'd1);
      chk_eq("R1", "done", 32'(rsp_done), 32'd0);
      chk_eq("R1", "BALE", 32'(bus_bale), 32'd0);
      chk_eq("R1", "strobes", 32'({bus_memr_n, bus_memw_n, bus_ior_n, bus_iow_n,
                                   bus_smemr_n, bus_smemw_n, bus_sbhe_n}), 32'h7F);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // directed corners
      run_txn(24'h0A1234, 16'h0, 0, 0, 1, 1, 1, 0, 0);   // R3 16-bit memory read
      run_txn(24'h0A1236, 16'h0, 0, 0, 1, 1, 1, 1, 0);   // R3 zero wait
      run_txn(24'h000300, 16'h0, 0, 1, 1, 1, 1, 1, 0);   // R4 I/O 16, zero wait ignored
      run_txn(24'h0C0001, 16'h0, 0, 0, 0, 0, 0, 1, 0);   // R4 byte cycle, zero wait ignored
      run_txn(24'h0C0005, 16'h0, 0, 0, 0, 1, 1, 0, 0);   // R11 odd byte from high lane
      run_txn(24'h0D0010, 16'h0, 0, 0, 1, 0, 0, 0, 0);   // R10 split read
      run_txn(24'h0D0021, 16'hBEEF, 1, 0, 1, 0, 0, 0, 0); // R10 split write, bit 0 forced
      run_txn(24'h000310, 16'hCAFE, 1, 1, 0, 0, 0, 0, 0); // R12 I/O byte write
      run_txn(24'h0E0000, 16'h0, 0, 0, 1, 1, 1, 0, 12);  // R6 stretched
      run_txn(24'h0E0002, 16'h1357, 1, 0, 1, 1, 1, 0, 3); // R6 stretch on zero-length wait
      run_txn(24'h0E0004, 16'h0, 0, 0, 0, 0, 0, 0, 300); // R7 timeout
      run_txn(24'h000320, 16'h0, 0, 1, 1, 0, 1, 0, 0);   // R5 split I/O, second half 16-bit select
      run_txn(24'hF00000, 16'h2468, 1, 0, 1, 1, 1, 0, 0); // R9 above first megabyte
      run_txn(24'h100001, 16'h0, 0, 0, 0, 0, 0, 0, 0);   // R9 boundary just above

      // constrained random traffic
      for (int i = 0; i < 60; i++) begin
         logic [23:0] a;
         int w;
         a = 24'($urandom);
         if ($urandom % 2 == 0) a[23:20] = 4'h0;
         w = ($urandom % 4 == 0) ? int'($urandom % 20) : 0;
         run_txn(a, 16'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                 1'($urandom), 1'($urandom), 1'($urandom), w);
      end
      finish_run();
   end

endmodule